// File: doc/BRIEF.md
# Interrupt Event State Buffer Controller

This block holds a two-bit event state for each interrupt source and merges repeated triggers. A source that fires again while it is still being serviced is marked once as queued and is not delivered a second time. Software and devices reach the state through a load/store window in which every source has its own page. A store at page offset zero raises a trigger. Loads at fixed offsets inside the page read the state, perform an end-of-interrupt, or overwrite the state and return the earlier value in one atomic step.

Each state holds a pending bit P (bit 1) and a queued bit Q (bit 0). The encodings are: 00 idle, 10 pending, 11 pending with a further trigger waiting, and 01 off. Per-source valid and mask flags come in from outside. When a trigger is accepted and the source is unmasked, the block pulses that source's notify line. Each accepted access is answered exactly one cycle later by a response strobe carrying data, an error flag and the logical source number.

Top module: `irq_pq_bank`

## Requirements
- R1: After reset every source is in state 01 (off), and rsp_valid, rsp_err, rsp_data, rsp_lisn and notify are all zero.
- R2: A good store at offset 0x000 is a trigger. It moves 00 to 10, 10 to 11 and 11 to 11, and each of these asks for a notify. A source in 01 stays in 01 and asks for nothing. A good store returns data 0.
- R3: A good load at offset 0x000 is an end-of-interrupt. It moves 11 to 10 and returns 1. It moves 10 to 00 and returns 0. It leaves 00 and 01 unchanged and returns 0.
- R4: A good load at offset 0x800 returns the current state zero-extended to 64 bits, with P in bit 1 and Q in bit 0. The state is not changed.
- R5: A good load at offset 0xC00, 0xD00, 0xE00 or 0xF00 returns the previous state and writes address bits [9:8] as the new state, in the same cycle.
- R6: The offset is address bits [11:8]. A store to any nonzero offset, or a load at an offset other than 0x0, 0x8 and 0xC–0xF, changes nothing and responds with rsp_err=1 and all-ones data.
- R7: The source index is address >> SHIFT. If the index is NSRC or more, or the source's valid flag is clear, the access changes nothing and responds with all-ones data and rsp_err=1.
- R8: An access is accepted only when acc_size is 8 and acc_be is 1. Any other access changes nothing and responds with all-ones data and rsp_err=1.
- R9: notify[i] rises for exactly one cycle, in the response cycle, only when a trigger on source i asked for a notify and src_mask[i] was clear. A masked trigger still changes the state.
- R10: Every access is answered by rsp_valid exactly one cycle later, and rsp_lisn then equals the index plus BASE, modulo 2^LW.
- R11: An access to one source never changes the state of any other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | AW | Byte address within the window |
| acc_size | input | 4 | Access size in bytes |
| acc_be | input | 1 | 1 = big-endian access |
| src_valid | input | NSRC | Per-source valid flags |
| src_mask | input | NSRC | Per-source mask flags |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Load result |
| rsp_err | output | 1 | Access rejected or undefined |
| rsp_lisn | output | LW | Logical source number of the access |
| notify | output | NSRC | One-cycle notify pulse per source |

## Verification
Directed sequences walk one source through every state under triggers, end-of-interrupts and forced sets. This separates the coalescing path from the re-fire path, and shows whether the swap returns the old state or the new one. Masked, invalid, out-of-range, wrongly sized, little-endian and wrong-offset accesses are each checked for a silent state and an error response. A long pseudo-random mix of sources, offsets and masks, compared every cycle against a behavioural model, catches cross-talk between neighbouring state fields and lost updates on back-to-back accesses.

// File: rtl/irq_pq_bank.sv
module irq_pq_bank #(
  parameter int NSRC  = 8,
  parameter int SHIFT = 12,
  parameter int AW    = 16,
  parameter int BASE  = 0,
  parameter int LW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [AW-1:0]   acc_addr,
  input  logic [3:0]      acc_size,
  input  logic            acc_be,
  input  logic [NSRC-1:0] src_valid,
  input  logic [NSRC-1:0] src_mask,
  output logic            rsp_valid,
  output logic [63:0]     rsp_data,
  output logic            rsp_err,
  output logic [LW-1:0]   rsp_lisn,
  output logic [NSRC-1:0] notify
);
  localparam int IW = AW - SHIFT;

  logic [2*NSRC-1:0] pq_q;
  logic [IW-1:0]     idx;
  logic [3:0]        op;
  logic [NSRC-1:0]   hit;
  logic [1:0]        cur, nxt;
  logic              sel_ok, sel_mask, ok, fire, err;
  logic [63:0]       data;

  assign idx = acc_addr[AW-1:SHIFT];
  assign op  = acc_addr[11:8];
  wire unused_addr = &{1'b0, acc_addr};

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hit[g] = (idx == IW'(g));
  end

  always_comb begin
    cur = '0;
    sel_ok = 1'b0;
    sel_mask = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (hit[i]) begin
        cur = pq_q[2*i +: 2];
        sel_ok = src_valid[i];
        sel_mask = src_mask[i];
      end
    end
  end

  assign ok = acc_valid && acc_size == 4'd8 && acc_be && sel_ok;

  always_comb begin
    nxt  = cur;
    data = '1;
    err  = !ok;
    fire = 1'b0;
    if (ok) begin
      if (acc_write) begin
        if (op == 4'h0) begin
          data = '0;
          fire = (cur != 2'b01);
          if (cur != 2'b01) nxt = {1'b1, cur[1]};
        end else begin
          err = 1'b1;
        end
      end else begin
        case (op)
          4'h0: begin
            data = {63'd0, cur == 2'b11};
            if (cur[1]) nxt = {1'b1, 1'b0} & {1'b1, 1'b0} & {cur[0], 1'b0};
          end
          4'h8: data = {62'd0, cur};
          4'hC, 4'hD, 4'hE, 4'hF: begin
            data = {62'd0, cur};
            nxt  = op[1:0];
          end
          default: err = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq_q      <= {NSRC{2'b01}};
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_lisn  <= '0;
      notify    <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_data  <= acc_valid ? data : '0;
      rsp_err   <= acc_valid && err;
      rsp_lisn  <= acc_valid ? LW'(idx) + LW'(BASE) : '0;
      notify    <= (fire && !sel_mask) ? hit : '0;
      for (int i = 0; i < NSRC; i++)
        if (ok && !err && hit[i]) pq_q[2*i +: 2] <= nxt;
    end
  end
endmodule

// File: rtl/irq_pq_bank_chk.sv
module irq_pq_bank_chk #(
  parameter int NSRC = 8,
  parameter int AW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [AW-1:0]   acc_addr,
  input logic [NSRC-1:0] src_mask,
  input logic            rsp_valid,
  input logic [63:0]     rsp_data,
  input logic            rsp_err,
  input logic [NSRC-1:0] notify
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid); // R10
  AST_RSP_ONLY_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid)); // R10
  AST_NOTIFY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(notify)); // R9
  AST_NOTIFY_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (|notify) |-> ($past(acc_valid && acc_write) && rsp_valid && !rsp_err)); // R2
  AST_NOTIFY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|notify) |-> ((notify & $past(src_mask)) == '0)); // R9
  AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '1)); // R6
  AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && $past(!acc_write && acc_addr[11:8] == 4'h0))
      |-> (rsp_data[63:1] == '0)); // R3
endmodule

bind irq_pq_bank irq_pq_bank_chk #(.NSRC(NSRC), .AW(AW)) u_chk (.*);

// File: tb/tb_irq_pq_bank.sv
module tb_irq_pq_bank;
  localparam int NSRC = 8, SHIFT = 12, AW = 16, BASE = 40, LW = 8;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_be = 1;
  logic [AW-1:0] acc_addr = '0;
  logic [3:0] acc_size = 4'd8;
  logic [NSRC-1:0] src_valid = '1, src_mask = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_data;
  logic [LW-1:0] rsp_lisn;
  logic [NSRC-1:0] notify;

  irq_pq_bank #(.NSRC(NSRC), .SHIFT(SHIFT), .AW(AW), .BASE(BASE), .LW(LW)) dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R1";
  bit live = 0;

  int m_pq [NSRC];
  logic e_valid, e_err;
  logic [63:0] e_data;
  logic [LW-1:0] e_lisn;
  logic [NSRC-1:0] e_notify;

  always @(posedge clk or negedge rst_n) begin : model
    int i, op, st, ns;
    bit good, er, nf;
    logic [63:0] d;
    if (!rst_n) begin
      for (int k = 0; k < NSRC; k++) m_pq[k] = 1;
      e_valid <= 0; e_err <= 0; e_data <= 0; e_lisn <= 0; e_notify <= 0;
    end else begin
      i = int'(acc_addr) >> SHIFT;
      op = (int'(acc_addr) >> 8) & 15;
      good = acc_valid && acc_size == 8 && acc_be && i < NSRC && src_valid[i % NSRC];
      d = '1; er = 1; nf = 0;
      if (good) begin
        st = m_pq[i]; ns = st;
        if (acc_write) begin
          if (op == 0) begin
            er = 0; d = 0;
            if (st == 0) ns = 2; else if (st == 2) ns = 3; else if (st == 3) ns = 3;
            nf = (st != 1);
          end
        end else if (op == 0) begin
          er = 0;
          d = (st == 3) ? 1 : 0;
          if (st == 3) ns = 2; else if (st == 2) ns = 0;
        end else if (op == 8) begin
          er = 0; d = st;
        end else if (op >= 12) begin
          er = 0; d = st; ns = op - 12;
        end
        if (!er) m_pq[i] = ns;
      end
      e_valid <= acc_valid;
      e_err <= acc_valid && er;
      e_data <= acc_valid ? d : 0;
      e_lisn <= acc_valid ? LW'(i + BASE) : 0;
      e_notify <= (nf && !src_mask[i % NSRC]) ? NSRC'(1) << i : 0;
    end
  end

  always @(negedge clk) if (live) begin
    total++;
    if ({rsp_valid, rsp_err, rsp_data, rsp_lisn, notify} !==
        {e_valid, e_err, e_data, e_lisn, e_notify}) begin
      bad++;
      $display("FAIL %s model: got v=%b e=%b d=%h n=%0d notify=%b exp v=%b e=%b d=%h n=%0d notify=%b",
               tag, rsp_valid, rsp_err, rsp_data, rsp_lisn, notify,
               e_valid, e_err, e_data, e_lisn, e_notify);
    end
  end

  task automatic check(string t, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", t, got, exp);
    end
  endtask

  task automatic acc(string t, bit wr, int src, int off, int sz = 8, bit be = 1);
    tag = t;
    acc_valid = 1; acc_write = wr; acc_size = 4'(sz); acc_be = be;
    acc_addr = AW'((src << SHIFT) | off);
    @(negedge clk);
    acc_valid = 0;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    src_valid = 8'b1101_1111;
    src_mask  = 8'b0000_1000;
    repeat (3) @(negedge clk);
    check("R1 outputs", {rsp_valid, rsp_err, notify, rsp_lisn}, 0);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    acc("R1", 0, 0, 'h800);       check("R1 reset off", rsp_data, 1);
    acc("R10", 0, 2, 'h800);      check("R10 lisn", 64'(rsp_lisn), 42);
    acc("R5", 0, 0, 'hC00);       check("R5 old", rsp_data, 1);
    acc("R2", 1, 0, 0);           check("R2 notify", 64'(notify), 1);
    acc("R2", 1, 0, 0);           check("R2 coalesce notify", 64'(notify), 1);
    acc("R2", 1, 0, 0);
    acc("R4", 0, 0, 'h800);       check("R4 queued", rsp_data, 3);
    acc("R2", 1, 1, 0);           check("R2 off no notify", 64'(notify), 0);
    acc("R3", 0, 0, 0);           check("R3 refire", rsp_data, 1);
    acc("R3", 0, 0, 0);           check("R3 pending", rsp_data, 0);
    acc("R3", 0, 0, 'h800);       check("R3 idle", rsp_data, 0);
    acc("R3", 0, 1, 0);           check("R3 off", rsp_data, 0);
    acc("R9", 0, 3, 'hC00);
    acc("R9", 1, 3, 0);           check("R9 masked", 64'(notify), 0);
    acc("R9", 0, 3, 'h800);       check("R9 state moved", rsp_data, 2);
    acc("R6", 1, 0, 'h800);       check("R6 err", 64'(rsp_err), 1);
    acc("R6", 0, 0, 'h400);       check("R6 ones", rsp_data, '1);
    acc("R6", 0, 0, 'h800);       check("R6 unchanged", rsp_data, 0);
    acc("R7", 0, 9, 'h800);       check("R7 range", rsp_data, '1);
    acc("R7", 0, 5, 'hF00);       check("R7 invalid", rsp_data, '1);
    src_valid[5] = 1;
    acc("R7", 0, 5, 'h800);       check("R7 untouched", rsp_data, 1);
    acc("R8", 0, 0, 'hF00, 4);    check("R8 size", rsp_data, '1);
    acc("R8", 1, 0, 0, 8, 0);     check("R8 endian notify", 64'(notify), 0);
    acc("R8", 0, 0, 'h800);       check("R8 untouched", rsp_data, 0);
    for (int s = 0; s < NSRC; s++) acc("R11", 0, s, 'hC00 + ((s % 4) << 8));
    for (int s = 0; s < NSRC; s++) begin
      acc("R11", 0, s, 'h800);
      check("R11 field", rsp_data, 64'(s % 4));
    end
    for (int n = 0; n < 3000; n++) begin
      int offs [7] = '{'h000, 'h800, 'hC00, 'hD00, 'hE00, 'hF00, 'h400};
      src_mask = NSRC'($urandom);
      tag = "R11 random";
      acc_valid = ($urandom % 5) != 0;
      acc_write = ($urandom % 3) == 0;
      acc_size = ($urandom % 10) == 0 ? 4'd4 : 4'd8;
      acc_be = ($urandom % 12) != 0;
      acc_addr = AW'((($urandom % 10) << SHIFT) | offs[$urandom % 7]);
      @(negedge clk);
    end
    acc_valid = 0;
    @(negedge clk);
    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule